// File: doc/BRIEF.md
# Memory Access Ordering Logger

This block sits beside a cache controller during bring-up and keeps a trace of which core touched which cache line, and in what relative order. It holds an internal table of line metadata. Each line has a running access count and an access vector with one sequence-ID field per core. Every granted load or store from a core raises the line's count. The new count goes into that core's field of the vector.

At the same time, the block emits a log record on that core's log-write lane. The record holds the operation, the line address and a snapshot of the updated vector. Each core has its own log region, written in its own program order. A later checking pass uses these records to build its ordering graph.

Control is a three-state machine:
- **S_OFF**: logging is idle.
- **S_ARMED**: accesses are recorded.
- **S_FULL**: logging has halted and `log_full` is high.

The transitions are:
- **S_OFF → S_ARMED** when `enable` is high.
- **S_ARMED → S_OFF** when `enable` drops.
- **S_ARMED → S_FULL** when a core's log region receives its last slot, or when a sequence count reaches its maximum.
- **clear** from any state goes to S_ARMED if `enable` is high, otherwise to S_OFF.

S_FULL is left only through `clear`. The default parameters are 2 cores, 4-bit line addresses (16 tracked lines), 4-bit sequence IDs and 16 log slots per core.

Top module: `mem_order_logger`

## Requirements
- R1: A granted access sets the accessing core's field in the line's vector to the line count plus one, and the count takes that value. With two cores, the sequence "core 0 store, core 1 store, core 0 store" on one line leaves core 0 at 3 and core 1 at 2.
- R2: Loads and stores alike produce a record one clock after the event. Each record is `{op, line, field[NCORES-1] .. field[0]}`, with op 1 for a store and 0 for a load, and field[0] in the least significant SEQ_W bits.
- R3: Each core's log address starts at 0 after reset or clear and rises by one per record, so records appear in that core's issue order.
- R4: When several cores hit the same line in one cycle, the lower core number is updated first. Each of those cores gets a distinct, increasing sequence ID, and a higher core's record shows the lower cores' new IDs.
- R5: When a core has written its LOG_DEPTH-th record, `log_full` rises with that record. No further record is written, and the log address never goes past LOG_DEPTH-1.
- R6: A record whose sequence ID equals the all-ones maximum is written and raises `log_full` with it. A same-cycle access that would pass the maximum is dropped with no record.
- R7: While `enable` is low, events produce no record and leave line counts and vectors unchanged.
- R8: `clear` zeroes all counts, vectors and log addresses and drops `log_full`. It produces no record in its own cycle.
- R9: After reset no record is written and `log_full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Turns recording on; low makes the block inert |
| clear | input | 1 | Synchronous restart of all tracking state |
| ev_valid | input | NCORES | Per-core access strobe |
| ev_store | input | NCORES | Per-core operation, 1 = store, 0 = load |
| ev_line | input | NCORES*ADDR_W | Per-core line address, core 0 in the low bits |
| log_we | output | NCORES | Per-core log-write strobe |
| log_addr | output | NCORES*PTR_W | Per-core slot index within that core's log region |
| log_data | output | NCORES*REC_W | Per-core record |
| log_full | output | 1 | Logging halted, checking may begin |

## Verification
The assertions assume that every event arrives as a single-cycle strobe, with the lane number standing for the core number. They also assume that a line address is stable while its strobe is high, and that `enable` and `clear` change only between clock edges. The bench drives all inputs on the falling edge and returns the strobes to zero after each cycle. It keeps a line's count within range except where the saturation behaviour is the subject of the test, and it raises `enable` one idle cycle before sending the first event that should be recorded.

// File: rtl/olog_pkg.sv
package olog_pkg;

    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_ARMED = 2'd1,
        S_FULL  = 2'd2
    } olog_state_e;

endpackage

// File: rtl/olog_meta_table.sv
module olog_meta_table #(
    parameter int NCORES = 2,
    parameter int ADDR_W = 4,
    parameter int SEQ_W  = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clear,
    input  logic [NCORES-1:0][ADDR_W-1:0]         line,
    output logic [NCORES-1:0][SEQ_W-1:0]          rd_cnt,
    output logic [NCORES-1:0][NCORES-1:0][SEQ_W-1:0] rd_vec,
    input  logic [NCORES-1:0]                     wr_en,
    input  logic [NCORES-1:0][SEQ_W-1:0]          wr_seq
);
    localparam int NLINES = 1 << ADDR_W;

    logic [NLINES-1:0][SEQ_W-1:0]             cnt_q;
    logic [NLINES-1:0][NCORES-1:0][SEQ_W-1:0] vec_q;

    always_comb begin
        for (int i = 0; i < NCORES; i++) begin
            rd_cnt[i] = cnt_q[line[i]];
            rd_vec[i] = vec_q[line[i]];
        end
    end

    // Lanes applied in ascending order: the highest granted lane on a line
    // carries the largest ID, so its count write wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            vec_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
            vec_q <= '0;
        end else begin
            for (int i = 0; i < NCORES; i++) begin
                if (wr_en[i]) begin
                    cnt_q[line[i]]    <= wr_seq[i];
                    vec_q[line[i]][i] <= wr_seq[i];
                end
            end
        end
    end

endmodule

// File: rtl/olog_seq_alloc.sv
module olog_seq_alloc #(
    parameter int NCORES = 2,
    parameter int ADDR_W = 4,
    parameter int SEQ_W  = 4
) (
    input  logic                                     accept,
    input  logic [NCORES-1:0]                        ev_valid,
    input  logic [NCORES-1:0][ADDR_W-1:0]            line,
    input  logic [NCORES-1:0][SEQ_W-1:0]             rd_cnt,
    input  logic [NCORES-1:0][NCORES-1:0][SEQ_W-1:0] rd_vec,
    output logic [NCORES-1:0]                        grant,
    output logic [NCORES-1:0][SEQ_W-1:0]             seq,
    output logic [NCORES-1:0][NCORES-1:0][SEQ_W-1:0] rec_vec,
    output logic                                     hit_max
);
    localparam logic [SEQ_W:0] SEQ_MAX = {1'b0, {SEQ_W{1'b1}}};
    localparam logic [SEQ_W:0] ONE     = {{SEQ_W{1'b0}}, 1'b1};

    logic [NCORES-1:0][SEQ_W:0] wide;

    // Rank each lane behind lower lanes that target the same line.
    always_comb begin
        hit_max = 1'b0;
        for (int i = 0; i < NCORES; i++) begin
            wide[i] = {1'b0, rd_cnt[i]} + ONE;
            for (int j = 0; j < i; j++) begin
                if (ev_valid[j] && (line[j] == line[i])) begin
                    wide[i] = wide[i] + ONE;
                end
            end
            grant[i] = accept && ev_valid[i] && (wide[i] <= SEQ_MAX);
            seq[i]   = wide[i][SEQ_W-1:0];
            if (grant[i] && (wide[i] == SEQ_MAX)) begin
                hit_max = 1'b1;
            end
        end
    end

    // Snapshot after this lane's update, including lower lanes on the line.
    always_comb begin
        for (int i = 0; i < NCORES; i++) begin
            rec_vec[i] = rd_vec[i];
            for (int j = 0; j <= i; j++) begin
                if (grant[j] && (line[j] == line[i])) begin
                    rec_vec[i][j] = seq[j];
                end
            end
        end
    end

endmodule

// File: rtl/olog_log_ptr.sv
module olog_log_ptr #(
    parameter int LOG_DEPTH = 16,
    parameter int PTR_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr,
    output logic             at_end
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(LOG_DEPTH - 1);
    localparam logic [PTR_W-1:0] STOP = PTR_W'(LOG_DEPTH);

    assign at_end = adv && (ptr == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clear) begin
            ptr <= '0;
        end else if (adv && (ptr != STOP)) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/mem_order_logger.sv
module mem_order_logger
    import olog_pkg::*;
#(
    parameter  int NCORES    = 2,
    parameter  int ADDR_W    = 4,
    parameter  int SEQ_W     = 4,
    parameter  int LOG_DEPTH = 16,
    localparam int PTR_W     = $clog2(LOG_DEPTH + 1),
    localparam int REC_W     = 1 + ADDR_W + NCORES * SEQ_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic                      clear,
    input  logic [NCORES-1:0]         ev_valid,
    input  logic [NCORES-1:0]         ev_store,
    input  logic [NCORES*ADDR_W-1:0]  ev_line,
    output logic [NCORES-1:0]         log_we,
    output logic [NCORES*PTR_W-1:0]   log_addr,
    output logic [NCORES*REC_W-1:0]   log_data,
    output logic                      log_full
);
    olog_state_e state_q, state_d;

    logic [NCORES-1:0][ADDR_W-1:0]            line;
    logic [NCORES-1:0][SEQ_W-1:0]             rd_cnt;
    logic [NCORES-1:0][NCORES-1:0][SEQ_W-1:0] rd_vec;
    logic [NCORES-1:0]                        grant;
    logic [NCORES-1:0][SEQ_W-1:0]             seq;
    logic [NCORES-1:0][NCORES-1:0][SEQ_W-1:0] rec_vec;
    logic [NCORES-1:0][PTR_W-1:0]             ptr;
    logic [NCORES-1:0]                        at_end;
    logic                                     hit_max;
    logic                                     accept;
    logic                                     fill;

    assign line   = ev_line;
    assign accept = (state_q == S_ARMED) && enable && !clear;
    assign fill   = hit_max || (|at_end);

    olog_meta_table #(.NCORES(NCORES), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .line   (line),
        .rd_cnt (rd_cnt),
        .rd_vec (rd_vec),
        .wr_en  (grant),
        .wr_seq (seq)
    );

    olog_seq_alloc #(.NCORES(NCORES), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) u_alloc (
        .accept   (accept),
        .ev_valid (ev_valid),
        .line     (line),
        .rd_cnt   (rd_cnt),
        .rd_vec   (rd_vec),
        .grant    (grant),
        .seq      (seq),
        .rec_vec  (rec_vec),
        .hit_max  (hit_max)
    );

    for (genvar c = 0; c < NCORES; c++) begin : g_ptr
        olog_log_ptr #(.LOG_DEPTH(LOG_DEPTH), .PTR_W(PTR_W)) u_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (clear),
            .adv    (grant[c]),
            .ptr    (ptr[c]),
            .at_end (at_end[c])
        );
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = enable ? S_ARMED : S_OFF;
        end else begin
            unique case (state_q)
                S_OFF:   if (enable) state_d = S_ARMED;
                S_ARMED: begin
                    if (!enable)   state_d = S_OFF;
                    else if (fill) state_d = S_FULL;
                end
                S_FULL:  state_d = S_FULL;
                default: state_d = S_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            log_we   <= '0;
            log_addr <= '0;
            log_data <= '0;
        end else begin
            for (int i = 0; i < NCORES; i++) begin
                log_we[i] <= grant[i];
                if (grant[i]) begin
                    log_addr[i*PTR_W +: PTR_W] <= ptr[i];
                    log_data[i*REC_W +: REC_W] <= {ev_store[i], line[i], rec_vec[i]};
                end
            end
        end
    end

    assign log_full = (state_q == S_FULL);

endmodule

// File: rtl/olog_checker.sv
module olog_checker #(
    parameter int NCORES    = 2,
    parameter int ADDR_W    = 4,
    parameter int SEQ_W     = 4,
    parameter int LOG_DEPTH = 16
) (
    input logic                                              clk,
    input logic                                              rst_n,
    input logic                                              enable,
    input logic                                              clear,
    input logic [NCORES-1:0]                                 log_we,
    input logic [NCORES*$clog2(LOG_DEPTH+1)-1:0]             log_addr,
    input logic [NCORES*(1+ADDR_W+NCORES*SEQ_W)-1:0]         log_data,
    input logic                                              log_full
);
    localparam int PTR_W = $clog2(LOG_DEPTH + 1);
    localparam int REC_W = 1 + ADDR_W + NCORES * SEQ_W;

    AST_HALT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (log_full && !clear) |=> (log_we == '0));   // R5

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (log_we == '0));                 // R7

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!log_full && (log_we == '0)));    // R8

    for (genvar i = 0; i < NCORES; i++) begin : g_lane
        AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            log_we[i] |-> (log_addr[i*PTR_W +: PTR_W] < PTR_W'(LOG_DEPTH)));   // R5

        AST_OWN_FIELD_SET: assert property (@(posedge clk) disable iff (!rst_n)
            log_we[i] |-> (log_data[i*REC_W + i*SEQ_W +: SEQ_W] != '0));      // R1

        if (i > 0) begin : g_pair
            AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                (log_we[i] && log_we[i-1] &&
                 (log_data[i*REC_W + NCORES*SEQ_W +: ADDR_W] ==
                  log_data[(i-1)*REC_W + NCORES*SEQ_W +: ADDR_W]))
                |-> (log_data[i*REC_W + i*SEQ_W +: SEQ_W] >
                     log_data[i*REC_W + (i-1)*SEQ_W +: SEQ_W]));               // R4
        end
    end

endmodule

bind mem_order_logger olog_checker #(
    .NCORES(NCORES), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .LOG_DEPTH(LOG_DEPTH)
) u_olog_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .clear    (clear),
    .log_we   (log_we),
    .log_addr (log_addr),
    .log_data (log_data),
    .log_full (log_full)
);

// File: tb/tb_mem_order_logger.sv
module tb_mem_order_logger;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        clear = 1'b0;
    logic [1:0]  ev_valid = '0;
    logic [1:0]  ev_store = '0;
    logic [7:0]  ev_line = '0;
    logic [1:0]  log_we;
    logic [9:0]  log_addr;
    logic [25:0] log_data;
    logic        log_full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_order_logger dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
        .ev_valid(ev_valid), .ev_store(ev_store), .ev_line(ev_line),
        .log_we(log_we), .log_addr(log_addr), .log_data(log_data),
        .log_full(log_full)
    );

    // Row: {v0, s0, line0, v1, s1, line1 | we0, slot0, rec0, we1, slot1, rec1}
    // rec = {op, line, field1, field0}
    localparam logic [49:0] ROWS [NROWS] = '{
        {1'b1,1'b1,4'd2, 1'b0,1'b0,4'd0,  1'b1,5'd0,1'b1,4'd2,4'd0,4'd1,  1'b0,5'd0,13'd0},
        {1'b0,1'b0,4'd0, 1'b1,1'b1,4'd2,  1'b0,5'd0,13'd0,                1'b1,5'd0,1'b1,4'd2,4'd2,4'd1},
        {1'b1,1'b1,4'd2, 1'b0,1'b0,4'd0,  1'b1,5'd1,1'b1,4'd2,4'd2,4'd3,  1'b0,5'd0,13'd0},
        {1'b1,1'b0,4'd5, 1'b1,1'b0,4'd5,  1'b1,5'd2,1'b0,4'd5,4'd0,4'd1,  1'b1,5'd1,1'b0,4'd5,4'd2,4'd1},
        {1'b1,1'b0,4'd7, 1'b1,1'b1,4'd2,  1'b1,5'd3,1'b0,4'd7,4'd0,4'd1,  1'b1,5'd2,1'b1,4'd2,4'd4,4'd3},
        {1'b0,1'b0,4'd0, 1'b0,1'b0,4'd0,  1'b0,5'd0,13'd0,                1'b0,5'd0,13'd0},
        {1'b0,1'b0,4'd0, 1'b1,1'b0,4'd5,  1'b0,5'd0,13'd0,                1'b1,5'd3,1'b0,4'd5,4'd3,4'd1}
    };

    function automatic string row_tag(int k);
        if (k == 3) return "R4";
        if (k < 3)  return "R1";
        if (k == 4) return "R2";
        return "R3";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ev(logic v0, logic s0, logic [3:0] a0, logic v1, logic s1, logic [3:0] a1);
        ev_valid = {v1, v0};
        ev_store = {s1, s0};
        ev_line  = {a1, a0};
        @(negedge clk);
        ev_valid = '0;
    endtask

    task automatic pulse_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9 we", 32'(log_we), 32'd0);
        chk("R9 full", 32'(log_full), 32'd0);

        // R7: disabled, events on line 2 must leave no trace
        ev(1'b1, 1'b1, 4'd2, 1'b1, 1'b1, 4'd2);
        chk("R7 no record", 32'(log_we), 32'd0);
        enable = 1'b1;
        @(negedge clk);

        // Vector table; row 0 also proves the R7 events changed nothing
        for (int k = 0; k < NROWS; k++) begin
            logic [37:0] e;
            e = ROWS[k][37:0];
            ev(ROWS[k][49], ROWS[k][48], ROWS[k][47:44], ROWS[k][43], ROWS[k][42], ROWS[k][41:38]);
            chk(row_tag(k), 32'(log_we[0]), 32'(e[37]));
            if (e[37]) begin
                chk(row_tag(k), 32'(log_addr[4:0]), 32'(e[36:32]));
                chk(row_tag(k), 32'(log_data[12:0]), 32'(e[31:19]));
            end
            chk(row_tag(k), 32'(log_we[1]), 32'(e[18]));
            if (e[18]) begin
                chk(row_tag(k), 32'(log_addr[9:5]), 32'(e[17:13]));
                chk(row_tag(k), 32'(log_data[25:13]), 32'(e[12:0]));
            end
        end

        // R6: saturate line 3
        pulse_clear();
        chk("R8 full low after clear", 32'(log_full), 32'd0);
        chk("R8 no record on clear", 32'(log_we), 32'd0);
        for (int k = 1; k <= 14; k++) begin
            ev(1'b1, 1'b1, 4'd3, 1'b0, 1'b0, 4'd0);
        end
        chk("R6 field 14", 32'(log_data[3:0]), 32'd14);
        chk("R6 not yet full", 32'(log_full), 32'd0);
        ev(1'b1, 1'b1, 4'd3, 1'b1, 1'b1, 4'd3);
        chk("R6 max written", 32'({log_we[0], log_data[3:0]}), 32'h1F);
        chk("R6 overflow dropped", 32'(log_we[1]), 32'd0);
        chk("R6 full", 32'(log_full), 32'd1);
        ev(1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd4);
        chk("R6 halted", 32'(log_we), 32'd0);

        // R5: fill core 1 log with one load per line
        pulse_clear();
        for (int k = 0; k < 16; k++) begin
            ev(1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'(k));
            if (k == 14) chk("R5 not full at 15", 32'(log_full), 32'd0);
        end
        chk("R5 last slot", 32'(log_addr[9:5]), 32'd15);
        chk("R5 last record", 32'(log_data[25:13]), 32'({1'b0, 4'd15, 4'd1, 4'd0}));
        chk("R5 full", 32'(log_full), 32'd1);
        ev(1'b1, 1'b1, 4'd1, 1'b1, 1'b1, 4'd2);
        chk("R5 no write after full", 32'(log_we), 32'd0);

        // R8: after clear, counts and slots restart
        pulse_clear();
        ev(1'b1, 1'b1, 4'd3, 1'b0, 1'b0, 4'd0);
        chk("R8 slot restart", 32'(log_addr[4:0]), 32'd0);
        chk("R8 count restart", 32'(log_data[12:0]), 32'({1'b1, 4'd3, 4'd0, 4'd1}));

        // R7: dropping enable while armed
        enable = 1'b0;
        ev(1'b1, 1'b0, 4'd3, 1'b1, 1'b0, 4'd3);
        chk("R7 disarmed", 32'(log_we), 32'd0);
        enable = 1'b1;
        @(negedge clk);
        ev(1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 4'd3);
        chk("R7 line 3 unchanged", 32'(log_data[25:13]), 32'({1'b0, 4'd3, 4'd2, 4'd1}));

        finish_run();
    end

endmodule